// File: doc/BRIEF.md
# Three-Phase Complementary PWM Output Stage

This block drives the six gate signals of a three-phase half-bridge inverter (phases U, V and W, each with a high-side and a low-side gate). A single up-counting carrier sets the switching period. Each phase derives a reference level from one of three modes: pulse-width modulation against a per-phase compare value, forced active, or forced inactive. The high gate follows the reference and the low gate follows its complement, and each side has its own enable.

Phase mode and enable settings are written into a shadow word and are copied into the working configuration only when the commutation strobe is sampled, so that all three phases change in the same cycle. A gate never rises until its demand has been stable for the dead time, which keeps the two switches of a leg from conducting together. An active-high break input passes through a two-flop synchroniser and clears the main output enable. Once cleared, the enable stays clear until software writes the control word again. While the enable is clear, or a side is disabled, that gate is driven low and never left floating.

The period, the compare values and the control word take effect on the clock edge that samples their write. The default period of 3599 gives a 20 kHz carrier from a 72 MHz clock.

Top module: `pwm3_bridge_out`

## Requirements
- R1: The carrier counts up from 0 and wraps to 0 on the edge after it reaches the period value, or after it exceeds that value. Its cycle is therefore period+1 clocks. The period is written at address 0.
- R2: In mode 3'b110 the phase reference is active while the carrier is below the phase compare value. The compare values for U, V and W are written at addresses 1, 2 and 3. A compare of 0 keeps the reference inactive for the whole cycle, and a compare above the period keeps it active for the whole cycle.
- R3: Mode 3'b101 makes the reference active and mode 3'b100 makes it inactive. Every other code is treated as inactive.
- R4: The configuration word at address 4 holds phase p (U=0, V=1, W=2) in bits [5p+4:5p]: mode in [5p+2:5p], high enable in bit 5p+3 and low enable in bit 5p+4. The high gate follows the reference when its enable is set. The low gate follows the inverted reference when its enable is set. A disabled gate is held low.
- R5: A write to address 4 changes no output. The written value becomes the working configuration on the edge that samples `commute` high.
- R6: A gate rises only after its demand has held for DEAD_TICKS+1 consecutive samples, and it falls on the edge after its demand drops. When one side hands over to the other, both gates are low for exactly DEAD_TICKS cycles.
- R7: The high gate and the low gate of a phase are never high in the same cycle.
- R8: When `brk_in` rises, all six gates are low and the main enable is clear from the third rising clock edge after the change.
- R9: The main enable is set only by a write to address 5 with bit 0 equal to 1, and it is not set again when the break ends. Such a write has no effect while the synchronised break is still high.
- R10: After reset the carrier is 0, the period is PERIOD_RST, the compares are 0, the shadow and working configuration words are 0 (all phases inactive and disabled), the main enable is clear and all gates are low.
- R11: Take a phase whose low gate is on. If one commutation switches it to mode 3'b110 with compare 0 and only the high enable set, its high gate never rises and its low gate falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 3 | Register address: 0 period, 1-3 compares, 4 shadow configuration, 5 control |
| wr_data | input | CNT_W | Write data |
| commute | input | 1 | Commutation strobe: moves the shadow configuration into the working configuration |
| brk_in | input | 1 | Asynchronous break request, active high |
| gate_hi | output | 3 | High-side gates, bit 0 = U, bit 1 = V, bit 2 = W |
| gate_lo | output | 3 | Low-side gates, same bit order |
| out_enabled | output | 1 | Main output enable state |

## Verification
The hardest case to reach is the standstill direction reversal. A phase whose low gate is being held on is switched in a single commutation to PWM on its high side with compare 0. This must leave the high gate quiet. To reach it, the stimulus first parks a phase on its low side through one commutation, waits until the dead time has run out, and then swaps the shadow word. It does the same for a phase going from forced-on high to forced-on low, where the bench counts the cycles with both gates low. The break is applied while a gate is steadily on. A re-enable write is issued while the synchronised break is still high, and it must have no effect.

// File: rtl/pwm3_pkg.sv
// Package pwm3_pkg
// Shared constants and types for the three-phase output stage: mode codes,
// the per-phase configuration record and the register port address map.
package pwm3_pkg;

    localparam int NUM_PH = 3;

    localparam logic [2:0] MODE_OFF = 3'b100;
    localparam logic [2:0] MODE_ON  = 3'b101;
    localparam logic [2:0] MODE_PWM = 3'b110;

    // Per-phase record; packed so that mode sits in the low bits.
    typedef struct packed {
        logic       lo_en;
        logic       hi_en;
        logic [2:0] mode;
    } ph_cfg_t;

    localparam int CFG_BITS = $bits(ph_cfg_t);
    localparam int CFG_W    = NUM_PH * CFG_BITS;

    typedef ph_cfg_t [NUM_PH-1:0] bridge_cfg_t;

    localparam logic [2:0] ADDR_PERIOD = 3'd0;
    localparam logic [2:0] ADDR_CMP0   = 3'd1;
    localparam logic [2:0] ADDR_CFG    = 3'd4;
    localparam logic [2:0] ADDR_CTRL   = 3'd5;

endpackage

// File: rtl/pwm3_carrier.sv
// Module pwm3_carrier
// Up-counting carrier. Counts 0..period and wraps to 0. A count at or
// above the period (after the period is lowered) also wraps.
// Assumes the period is held in a register outside this module.
module pwm3_carrier #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt
);

    // Advance the carrier or wrap it at the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt >= period) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm3_regs.sv
// Module pwm3_regs
// Register port and control state: period, compare values, shadow and
// working configuration, break synchroniser and main output enable.
// Assumes CNT_W >= CFG_W so that one write carries a whole configuration.
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] PERIOD_RST = CNT_W'(3599)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [2:0]                   wr_addr,
    input  logic [CNT_W-1:0]             wr_data,
    input  logic                         commute,
    input  logic                         brk_in,
    output logic [CNT_W-1:0]             period,
    output logic [NUM_PH-1:0][CNT_W-1:0] cmp,
    output bridge_cfg_t                  act_cfg,
    output logic                         moe,
    output logic                         brk_sync
);

    bridge_cfg_t shadow_cfg;
    logic        brk_meta;
    logic        rearm_req;

    assign rearm_req = wr_en && (wr_addr == ADDR_CTRL) && wr_data[0];

    // Capture the carrier period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= PERIOD_RST;
        end else if (wr_en && wr_addr == ADDR_PERIOD) begin
            period <= wr_data;
        end
    end

    // One compare register per phase.
    for (genvar p = 0; p < NUM_PH; p++) begin : g_cmp
        // Capture this phase's compare value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp[p] <= '0;
            end else if (wr_en && wr_addr == (ADDR_CMP0 + 3'(p))) begin
                cmp[p] <= wr_data;
            end
        end
    end

    // Hold newly written phase settings until the next commutation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_cfg <= '0;
        end else if (wr_en && wr_addr == ADDR_CFG) begin
            shadow_cfg <= bridge_cfg_t'(wr_data[CFG_W-1:0]);
        end
    end

    // Move the shadow settings into use, all phases at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cfg <= '0;
        end else if (commute) begin
            act_cfg <= shadow_cfg;
        end
    end

    // Two-flop synchroniser for the asynchronous break request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_meta <= 1'b0;
            brk_sync <= 1'b0;
        end else begin
            brk_meta <= brk_in;
            brk_sync <= brk_meta;
        end
    end

    // Main enable: break clears it and wins; only a control write sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            moe <= 1'b0;
        end else if (brk_sync) begin
            moe <= 1'b0;
        end else if (rearm_req) begin
            moe <= 1'b1;
        end
    end

endmodule

// File: rtl/pwm3_deadband.sv
// Module pwm3_deadband
// Registered gate driver for one side of a leg. The output rises only after
// the demand has been held for DEAD_TICKS+1 samples and falls one edge after
// the demand drops. Assumes the two demands of a leg are never high together.
module pwm3_deadband #(
    parameter int DEAD_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic demand,
    output logic gate
);

    localparam int               RUN_W  = $clog2(DEAD_TICKS + 2);
    localparam logic [RUN_W-1:0] RUN_MX = RUN_W'(DEAD_TICKS);

    logic [RUN_W-1:0] run;

    // Count how long the demand has been held, saturating at the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= '0;
        end else if (!demand) begin
            run <= '0;
        end else if (run != RUN_MX) begin
            run <= run + 1'b1;
        end
    end

    // Drive the gate once the hold time is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
        end else begin
            gate <= demand && (run == RUN_MX);
        end
    end

endmodule

// File: rtl/pwm3_phase.sv
// Module pwm3_phase
// One half-bridge leg: decodes the mode into a reference level, gates the
// high side with the reference and the low side with its complement, and
// applies dead time on each side. Assumes `allow` already combines the main
// enable with the synchronised break.
module pwm3_phase
    import pwm3_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DEAD_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  ph_cfg_t          cfg,
    input  logic             allow,
    output logic             gate_hi,
    output logic             gate_lo
);

    logic ref_lvl;
    logic dem_hi;
    logic dem_lo;

    // Decode the mode into the phase reference; unknown codes stay inactive.
    always_comb begin
        unique case (cfg.mode)
            MODE_PWM: ref_lvl = (cnt < cmp);
            MODE_ON:  ref_lvl = 1'b1;
            MODE_OFF: ref_lvl = 1'b0;
            default:  ref_lvl = 1'b0;
        endcase
    end

    assign dem_hi = allow && cfg.hi_en && ref_lvl;
    assign dem_lo = allow && cfg.lo_en && !ref_lvl;

    pwm3_deadband #(.DEAD_TICKS(DEAD_TICKS)) u_db_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .demand (dem_hi),
        .gate   (gate_hi)
    );

    pwm3_deadband #(.DEAD_TICKS(DEAD_TICKS)) u_db_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .demand (dem_lo),
        .gate   (gate_lo)
    );

endmodule

// File: rtl/pwm3_bridge_out.sv
// Module pwm3_bridge_out
// Top of the three-phase complementary PWM output stage: register port,
// carrier and three legs. Gate bit order is U, V, W from bit 0.
// Assumes commute is a single-cycle strobe synchronous to clk.
module pwm3_bridge_out
    import pwm3_pkg::*;
#(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] PERIOD_RST = CNT_W'(3599),
    parameter int               DEAD_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              commute,
    input  logic              brk_in,
    output logic [NUM_PH-1:0] gate_hi,
    output logic [NUM_PH-1:0] gate_lo,
    output logic              out_enabled
);

    logic [CNT_W-1:0]             period;
    logic [CNT_W-1:0]             cnt;
    logic [NUM_PH-1:0][CNT_W-1:0] cmp;
    bridge_cfg_t                  act_cfg;
    logic                         moe;
    logic                         brk_sync;
    logic                         allow;

    pwm3_regs #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .commute  (commute),
        .brk_in   (brk_in),
        .period   (period),
        .cmp      (cmp),
        .act_cfg  (act_cfg),
        .moe      (moe),
        .brk_sync (brk_sync)
    );

    pwm3_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .cnt    (cnt)
    );

    // Gates are released only with the enable set and no break pending.
    assign allow       = moe && !brk_sync;
    assign out_enabled = moe;

    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
        pwm3_phase #(.CNT_W(CNT_W), .DEAD_TICKS(DEAD_TICKS)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .cmp     (cmp[p]),
            .cfg     (act_cfg[p]),
            .allow   (allow),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p])
        );
    end

endmodule

// File: rtl/pwm3_bridge_chk.sv
// Module pwm3_bridge_chk
// Assertion checker bound to pwm3_bridge_out. Watches the gates, the main
// enable, the break input and the working configuration. Assumes gate bit
// order U, V, W and the address map of pwm3_pkg.
module pwm3_bridge_chk
    import pwm3_pkg::*;
#(
    parameter int DEAD_TICKS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              brk_in,
    input logic              wr_en,
    input logic [2:0]        wr_addr,
    input logic              wr_bit0,
    input logic              commute,
    input logic [NUM_PH-1:0] gate_hi,
    input logic [NUM_PH-1:0] gate_lo,
    input logic              out_enabled,
    input logic [CFG_W-1:0]  act_cfg
);

    localparam int             QW     = $clog2(DEAD_TICKS + 2);
    localparam logic [QW-1:0]  Q_MAX  = QW'(DEAD_TICKS);

    // R7: a leg never drives both switches.
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R8: a break held for three samples has emptied every gate.
    a_r8_break_kills: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && brk_in && $past(brk_in) && $past(brk_in, 2))
        |=> (gate_hi == '0 && gate_lo == '0 && !out_enabled));

    // R9: the enable comes back only through a control write.
    a_r9_no_auto_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_enabled && !(wr_en && wr_addr == ADDR_CTRL && wr_bit0))
        |=> !out_enabled);

    // R5: without a strobe the working configuration does not move.
    a_r5_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        !commute |=> $stable(act_cfg));

    for (genvar p = 0; p < NUM_PH; p++) begin : g_leg_chk
        logic [QW-1:0] quiet;

        // Count cycles during which both gates of this leg were low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                quiet <= '0;
            end else if (gate_hi[p] || gate_lo[p]) begin
                quiet <= '0;
            end else if (quiet != Q_MAX) begin
                quiet <= quiet + 1'b1;
            end
        end

        // R6: a high gate rises only after a full dead time of quiet.
        a_r6_dead_hi: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[p]) |-> (quiet == Q_MAX));

        // R6: the same holds for the low gate.
        a_r6_dead_lo: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[p]) |-> (quiet == Q_MAX));
    end

endmodule

bind pwm3_bridge_out pwm3_bridge_chk #(.DEAD_TICKS(DEAD_TICKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .brk_in      (brk_in),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_bit0     (wr_data[0]),
    .commute     (commute),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .out_enabled (out_enabled),
    .act_cfg     (act_cfg)
);

// File: tb/tb_pwm3_bridge_out.sv
module tb_pwm3_bridge_out;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int DEAD       = 20;
    localparam int PER_RST    = 3599;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             commute = 1'b0;
    logic             brk_in = 1'b0;
    logic [2:0]       gate_hi;
    logic [2:0]       gate_lo;
    logic             out_enabled;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R10";

    pwm3_bridge_out #(
        .CNT_W(CNT_W), .PERIOD_RST(CNT_W'(PER_RST)), .DEAD_TICKS(DEAD)
    ) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commute(commute), .brk_in(brk_in),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .out_enabled(out_enabled)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int       m_cnt = 0;
    int       m_period = PER_RST;
    int       m_cmp [3] = '{0, 0, 0};
    bit [14:0] m_shadow = '0;
    bit [14:0] m_active = '0;
    bit       m_moe = 0, m_s1 = 0, m_s2 = 0;
    int       m_rh [3] = '{0, 0, 0};
    int       m_rl [3] = '{0, 0, 0};
    bit [2:0] m_oh = '0, m_ol = '0;

    function automatic bit m_ref(int p);
        int md = int'(m_active[5*p +: 3]);
        if (md == 6) return (m_cnt < m_cmp[p]);
        return (md == 5);
    endfunction

    always @(posedge clk) begin : model
        bit       allow, dh, dl;
        bit [14:0] nxt_act;
        if (!rst_n) begin
            m_cnt = 0; m_period = PER_RST; m_cmp = '{0, 0, 0};
            m_shadow = '0; m_active = '0; m_moe = 0; m_s1 = 0; m_s2 = 0;
            m_rh = '{0, 0, 0}; m_rl = '{0, 0, 0}; m_oh = '0; m_ol = '0;
        end else begin
            allow = m_moe && !m_s2;
            for (int p = 0; p < 3; p++) begin
                dh = allow && m_active[5*p+3] && m_ref(p);
                dl = allow && m_active[5*p+4] && !m_ref(p);
                m_oh[p] = dh && (m_rh[p] == DEAD);
                m_ol[p] = dl && (m_rl[p] == DEAD);
                m_rh[p] = dh ? ((m_rh[p] < DEAD) ? m_rh[p] + 1 : DEAD) : 0;
                m_rl[p] = dl ? ((m_rl[p] < DEAD) ? m_rl[p] + 1 : DEAD) : 0;
            end
            m_cnt   = (m_cnt >= m_period) ? 0 : m_cnt + 1;
            nxt_act = commute ? m_shadow : m_active;
            if (m_s2) m_moe = 0;
            else if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_moe = 1;
            m_s2 = m_s1;
            m_s1 = brk_in;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_period = int'(wr_data);
                    3'd1: m_cmp[0] = int'(wr_data);
                    3'd2: m_cmp[1] = int'(wr_data);
                    3'd3: m_cmp[2] = int'(wr_data);
                    3'd4: m_shadow = wr_data[14:0];
                    default: ;
                endcase
            end
            m_active = nxt_act;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare the design against the model every cycle, away from the edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check({cur_req, " gate_hi"}, int'(gate_hi), int'(m_oh));
            check({cur_req, " gate_lo"}, int'(gate_lo), int'(m_ol));
            check({cur_req, " out_enabled"}, int'(out_enabled), int'(m_moe));
            check("R7 overlap", int'(gate_hi & gate_lo), 0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk); commute = 1'b1;
        @(negedge clk); commute = 1'b0;
    endtask

    function automatic int ph(input int md, input bit hi, input bit lo);
        return (int'(lo) << 4) | (int'(hi) << 3) | md;
    endfunction

    function automatic int cw(input int u, input int v, input int w);
        return (w << 10) | (v << 5) | u;
    endfunction

    task automatic count(input int n, input int bitsel, input bit hi_side,
                         output int ones);
        ones = 0;
        repeat (n) begin
            @(negedge clk);
            if (hi_side ? gate_hi[bitsel] : gate_lo[bitsel]) ones++;
        end
    endtask

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c, both;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        @(negedge clk);
        cur_req = "R10";
        check("R10 reset gates", int'({gate_hi, gate_lo}), 0);
        check("R10 reset enable", int'(out_enabled), 0);

        // R1, R2, R4, R6: PWM on U, high side only.
        cur_req = "R1";
        wr(3'd0, 63);
        wr(3'd1, 40);
        wr(3'd4, cw(ph(6, 1, 0), 0, 0));
        strobe();
        wr(3'd5, 1);
        repeat (200) @(negedge clk);
        count(640, 0, 1, c);
        check("R1 R2 R6 high-gate cycles over ten carriers", c, 200);
        count(640, 0, 0, c);
        check("R4 disabled low gate stays low", c, 0);

        // Both sides enabled: low demand 24 cycles minus dead time.
        cur_req = "R6";
        wr(3'd4, cw(ph(6, 1, 1), 0, 0));
        strobe();
        repeat (200) @(negedge clk);
        count(640, 0, 0, c);
        check("R6 low-gate cycles over ten carriers", c, 40);

        // R5: shadow write without strobe changes nothing.
        cur_req = "R5";
        wr(3'd4, cw(ph(6, 1, 1), ph(5, 1, 0), ph(1, 1, 1)));
        count(100, 1, 1, c);
        check("R5 V high before commutation", c, 0);
        count(10, 2, 0, c);
        check("R5 W low before commutation", c, 0);
        strobe();
        repeat (DEAD + 10) @(negedge clk);
        cur_req = "R3";
        check("R3 forced active drives V high", int'(gate_hi[1]), 1);
        check("R3 unknown code drives W low gate", int'(gate_lo[2]), 1);
        check("R3 unknown code keeps W high gate off", int'(gate_hi[2]), 0);

        // R2 boundaries on U.
        cur_req = "R2";
        wr(3'd1, 0);
        repeat (100) @(negedge clk);
        count(128, 0, 1, c);
        check("R2 compare 0 never active", c, 0);
        wr(3'd1, 100);
        repeat (100) @(negedge clk);
        count(128, 0, 1, c);
        check("R2 compare above period always active", c, 128);

        // R6: U forced high -> forced low in one commutation.
        cur_req = "R6";
        wr(3'd4, cw(ph(5, 1, 1), ph(5, 1, 0), ph(4, 0, 1)));
        strobe();
        repeat (60) @(negedge clk);
        wr(3'd4, cw(ph(4, 1, 1), ph(5, 1, 0), ph(4, 0, 1)));
        strobe();
        both = 0; c = 0;
        repeat (40) begin
            @(negedge clk);
            if (!gate_hi[0] && !gate_lo[0]) both++;
            if (gate_lo[0]) c++;
        end
        check("R6 both gates low for the dead time", both, DEAD);
        check("R6 low gate on after the dead time", c, 40 - DEAD);

        // R11: V parked on low side, then reversed to PWM high with compare 0.
        cur_req = "R11";
        wr(3'd2, 0);
        wr(3'd4, cw(ph(4, 0, 1), ph(4, 0, 1), ph(4, 0, 1)));
        strobe();
        repeat (60) @(negedge clk);
        check("R11 V low gate parked on", int'(gate_lo[1]), 1);
        wr(3'd4, cw(ph(4, 0, 1), ph(6, 1, 0), ph(4, 0, 1)));
        strobe();
        count(200, 1, 1, c);
        check("R11 V high gate stays quiet", c, 0);
        check("R11 V low gate released", int'(gate_lo[1]), 0);

        // R8: break while U low gate is steadily on.
        cur_req = "R8";
        @(negedge clk); brk_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R8 gates low on third edge", int'({gate_hi, gate_lo}), 0);
        check("R8 enable cleared", int'(out_enabled), 0);

        // R9: re-enable while break is held, then after release.
        cur_req = "R9";
        repeat (10) @(negedge clk);
        wr(3'd5, 1);
        @(negedge clk);
        check("R9 write ignored during break", int'(out_enabled), 0);
        @(negedge clk); brk_in = 1'b0;
        repeat (40) @(negedge clk);
        check("R9 no automatic re-enable", int'(out_enabled), 0);
        check("R9 gates stay low", int'({gate_hi, gate_lo}), 0);
        wr(3'd5, 1);
        repeat (DEAD + 10) @(negedge clk);
        check("R9 re-enable restores U low gate", int'(gate_lo[0]), 1);

        // R10: reset mid-run.
        cur_req = "R10";
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 gates low in reset", int'({gate_hi, gate_lo}), 0);
        rst_n = 1'b1;
        wr(3'd5, 1);
        strobe();
        repeat (100) @(negedge clk);
        check("R10 cleared configuration keeps gates low",
              int'({gate_hi, gate_lo}), 0);
        check("R10 enable set by write", int'(out_enabled), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule